// File: doc/BRIEF.md
# Text Blink Phase Timer

This block produces the two-phase blink timing for a character display. Software programs one 8-bit period value. Its upper nibble sets how long the alternate colour pair is shown, and its lower nibble sets how long the normal pair is shown. Both durations are counted in steps of a fixed number of display fields, ten by default. Each step is therefore roughly one sixth of a second at 60 fields per second.

The block counts field ticks from the frame timing. It drives a phase flag and a colour-pair select that the pixel path combines with each cell's blink attribute. Writing the period value restarts the sequence in the alternate phase. A phase whose code is zero is never entered. The whole function runs only while the 80-column text mode is selected; in any other mode the outputs are held at the normal pair.

Top module: `blink_phase_timer`

## Requirements
- R1: After reset, `phase_on` is 0 and `pair_sel` is 0. Both codes read as zero, so the phase stays at normal until a period write.
- R2: A `reg_wr` pulse latches `reg_data[7:4]` as the alternate-phase code and `reg_data[3:0]` as the normal-phase code. It clears the field count. From the next cycle the phase is alternate if the alternate code is non-zero.
- R3: While in the alternate phase with code A (A not 0), the phase switches to normal at the clock edge that accepts the (A x STEP)-th counted field tick. This happens only if the normal code is non-zero. The phase changes only on accepted ticks, writes or enable changes.
- R4: While in the normal phase with code B (B not 0), the phase switches to alternate at the edge that accepts the (B x STEP)-th counted field tick. This happens only if the alternate code is non-zero.
- R5: An alternate code of 0 with a non-zero normal code keeps the phase at normal permanently.
- R6: A normal code of 0 with a non-zero alternate code keeps the phase at alternate permanently.
- R7: When both codes are 0, `phase_on` stays 0 whatever ticks arrive.
- R8: While `enable` is 0, `phase_on` and `pair_sel` are 0 and field ticks are not counted. When `enable` returns to 1, the sequence resumes from the point it reached.
- R9: `pair_sel` is 1 (alternate pair) exactly when `phase_on` is 1, and 0 (normal pair) otherwise.
- R10: A `reg_wr` in the same cycle as a `field_tick` takes precedence: the tick is not counted and the sequence restarts.
- R11: Code 15 with STEP = 10 gives a phase of exactly 150 counted field ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High while 80-column text mode is selected |
| field_tick | input | 1 | One-cycle pulse per display field |
| reg_wr | input | 1 | Period register write strobe |
| reg_data | input | 8 | Period value: [7:4] alternate code, [3:0] normal code |
| phase_on | output | 1 | 1 during the alternate (blink) phase |
| pair_sel | output | 1 | Colour pair select: 1 alternate, 0 normal |

## Verification
A miscounted field counter moves the phase edge by whole ticks. It shows at `phase_on` on the first expiry after a write, which is at most 150 ticks later. A wrong phase register or a lost latched code shows as a phase that never toggles, or that toggles into a zero-length phase, at the next expiry. The bench compares both outputs in every cycle against a reference model, so any divergence is reported in the cycle where it first appears.

// File: rtl/blink_pkg.sv
package blink_pkg;

    localparam int CODE_W        = 4;
    localparam int DEFAULT_STEP  = 10;
    localparam int MAX_CODE      = (1 << CODE_W) - 1;

    typedef enum logic {
        PH_NORMAL = 1'b0,
        PH_ALT    = 1'b1
    } phase_e;

    typedef struct packed {
        logic [CODE_W-1:0] alt_code;
        logic [CODE_W-1:0] norm_code;
    } period_t;

    function automatic int cnt_width(input int step);
        return $clog2(MAX_CODE * step + 1);
    endfunction

endpackage

// File: rtl/blink_period_reg.sv
module blink_period_reg
    import blink_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [2*CODE_W-1:0] wdata,
    output period_t             cfg
);

    period_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q <= period_t'(wdata);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/blink_field_cnt.sv
module blink_field_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] limit,
    output logic             expire,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (limit != '0) && (cnt_q == limit - CNT_W'(1));
    assign expire = advance && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (advance && (limit != '0)) begin
            if (at_end) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/blink_phase_fsm.sv
module blink_phase_fsm
    import blink_pkg::*;
#(
    parameter int STEP  = DEFAULT_STEP,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  period_t          load_cfg,
    input  period_t          cfg,
    input  logic             expire,
    output phase_e           phase,
    output logic [CNT_W-1:0] limit
);

    phase_e            phase_q;
    logic [CODE_W-1:0] cur_code;
    logic [CODE_W-1:0] next_code;

    function automatic logic [CNT_W-1:0] span(input logic [CODE_W-1:0] c);
        return CNT_W'(c) * CNT_W'(STEP);
    endfunction

    always_comb begin
        if (phase_q == PH_ALT) begin
            cur_code  = cfg.alt_code;
            next_code = cfg.norm_code;
        end else begin
            cur_code  = cfg.norm_code;
            next_code = cfg.alt_code;
        end
    end

    assign limit = span(cur_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_NORMAL;
        end else if (load) begin
            phase_q <= (load_cfg.alt_code != '0) ? PH_ALT : PH_NORMAL;
        end else if (expire && (next_code != '0)) begin
            phase_q <= (phase_q == PH_ALT) ? PH_NORMAL : PH_ALT;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/blink_phase_timer.sv
module blink_phase_timer
    import blink_pkg::*;
#(
    parameter int STEP = DEFAULT_STEP
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       field_tick,
    input  logic       reg_wr,
    input  logic [7:0] reg_data,
    output logic       phase_on,
    output logic       pair_sel
);

    localparam int CNT_W = cnt_width(STEP);

    period_t          cfg;
    phase_e           phase;
    logic [CNT_W-1:0] cur_limit;
    logic [CNT_W-1:0] fld_count;
    logic             expire;
    logic             advance;

    assign advance = enable && field_tick && !reg_wr;

    blink_period_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_data),
        .cfg   (cfg)
    );

    blink_field_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (reg_wr),
        .advance (advance),
        .limit   (cur_limit),
        .expire  (expire),
        .count   (fld_count)
    );

    blink_phase_fsm #(.STEP(STEP), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .load     (reg_wr),
        .load_cfg (period_t'(reg_data)),
        .cfg      (cfg),
        .expire   (expire),
        .phase    (phase),
        .limit    (cur_limit)
    );

    phase_e sel;
    always_comb begin
        sel = (enable && (phase == PH_ALT)) ? PH_ALT : PH_NORMAL;
    end

    assign phase_on = (sel == PH_ALT);
    assign pair_sel = sel;

endmodule

// File: rtl/blink_phase_timer_chk.sv
module blink_phase_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             field_tick,
    input logic             reg_wr,
    input logic [7:0]       reg_data,
    input logic             phase_on,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] limit
);

    // R8
    disabled_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !phase_on);

    // R5
    zero_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_data[7:4] == 4'd0) |=> !phase_on);

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_data[7:4] != 4'd0) |=> (phase_on == enable));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !$past(reg_wr) && !$past(field_tick))
        |-> $stable(phase_on));

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (limit != '0) |-> (count < limit));

endmodule

bind blink_phase_timer blink_phase_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .field_tick (field_tick),
    .reg_wr     (reg_wr),
    .reg_data   (reg_data),
    .phase_on   (phase_on),
    .count      (fld_count),
    .limit      (cur_limit)
);

// File: tb/tb_blink_phase_timer.sv
module tb_blink_phase_timer;

    localparam int STEP = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic       field_tick;
    logic       reg_wr;
    logic [7:0] reg_data;
    logic       phase_on;
    logic       pair_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;
    string tag = "R1";

    int m_alt, m_norm, m_cnt;
    bit m_ph;

    always #10 clk = ~clk;

    blink_phase_timer #(.STEP(STEP)) dut (
        .clk(clk), .rst(rst), .enable(enable), .field_tick(field_tick),
        .reg_wr(reg_wr), .reg_data(reg_data),
        .phase_on(phase_on), .pair_sel(pair_sel)
    );

    task automatic model_step();
        int lim, other;
        if (rst) begin
            m_alt = 0; m_norm = 0; m_cnt = 0; m_ph = 0;
        end else if (reg_wr) begin
            m_alt = reg_data[7:4]; m_norm = reg_data[3:0];
            m_cnt = 0; m_ph = (m_alt != 0);
        end else if (enable && field_tick) begin
            lim   = (m_ph ? m_alt : m_norm) * STEP;
            other = m_ph ? m_norm : m_alt;
            if (lim != 0) begin
                if (m_cnt + 1 == lim) begin
                    m_cnt = 0;
                    if (other != 0) m_ph = !m_ph;
                end else begin
                    m_cnt++;
                end
            end
        end
    endtask

    task automatic compare();
        bit exp_on;
        exp_on = m_ph && enable;
        checks++;
        if (phase_on !== exp_on) begin
            errors++;
            $display("FAIL %s phase_on actual %b expected %b (t=%0t)", tag, phase_on, exp_on, $time);
        end
        checks++;
        if (pair_sel !== exp_on) begin
            errors++;
            $display("FAIL R9 pair_sel actual %b expected %b (t=%0t)", pair_sel, exp_on, $time);
        end
    endtask

    task automatic cyc(input bit en, input bit wr, input logic [7:0] d, input bit tk);
        enable = en; reg_wr = wr; reg_data = d; field_tick = tk;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00, 1'b1);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; enable = 1'b1; field_tick = 1'b0; reg_wr = 1'b0; reg_data = 8'h00;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 8'h00, 1'b1);
        rst = 1'b0;
        tag = "R1";
        cyc(1'b1, 1'b0, 8'h00, 1'b0);
        ticks(30);

        // R2, R3, R4: alt 2 steps, normal 1 step
        tag = "R2"; cyc(1'b1, 1'b1, 8'h21, 1'b0);
        tag = "R3"; ticks(19);
        ticks(1);
        tag = "R4"; ticks(10);
        ticks(25);

        // R5
        tag = "R5"; cyc(1'b1, 1'b1, 8'h03, 1'b0); ticks(100);
        // R6
        tag = "R6"; cyc(1'b1, 1'b1, 8'h40, 1'b0); ticks(100);
        // R7
        tag = "R7"; cyc(1'b1, 1'b1, 8'h00, 1'b0); ticks(60);

        // R8: ticks while disabled are not counted
        tag = "R8"; cyc(1'b1, 1'b1, 8'h11, 1'b0); ticks(5);
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1);
        ticks(12);

        // R10: write wins over tick
        tag = "R10"; cyc(1'b1, 1'b1, 8'h12, 1'b0); ticks(9);
        cyc(1'b1, 1'b1, 8'h12, 1'b1);
        ticks(12);

        // R11: code 15 -> 150 ticks
        tag = "R11"; cyc(1'b1, 1'b1, 8'hF1, 1'b0); ticks(149); ticks(1); ticks(12);

        // constrained random mix
        tag = "R3";
        for (int i = 0; i < 20000; i++) begin
            bit en, wr, tk;
            en = ($urandom_range(0, 19) != 0);
            wr = ($urandom_range(0, 599) == 0);
            tk = ($urandom_range(0, 1) == 0);
            cyc(en, wr, 8'($urandom_range(0, 255)) & 8'h33, tk);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule